// File: doc/BRIEF.md
# Per-Channel Register Window Address Decoder

This block sits between a host register request port and a set of serial channels. It decodes a 16 KB register space. The low 4 KB is a shared control bank that only takes full 32-bit accesses. Above it, the space is cut into 512-byte windows, one per channel, starting at offset 0x1000. In each window, the first 256 bytes reach that channel's 8-bit register port, one byte at a time. The upper 256 bytes are a reserved transfer-engine area that reads as zero and ignores writes.

For every accepted request the decoder raises at most one downstream select. It passes the local offset and write data to the chosen target. One cycle later it returns the read data, zero-extended for channel bytes. Any access that finds no legal target gets no select and reads back zero. This covers a wrong access width, an index past the built channel count, and the reserved area. The channel register logic and the transfer engines are outside this block.

Top module: `mmio_win_decoder`

## Requirements
- R1: A request below offset 0x1000 with size code 2 (32-bit) raises `glb_sel` in the same cycle. It passes `glb_offset` = address bits [11:0], `glb_we` = `req_we` and `glb_wdata` = `req_wdata`.
- R2: A request below offset 0x1000 with size code 0 (byte), 1 (16-bit) or 3 (reserved) raises no select, and a read of it returns zero.
- R3: A byte request (size code 0) at or above 0x1000 whose local offset is below 0x100 raises exactly `ch_sel[n]`, with n = (address − 0x1000) / 0x200. It passes `ch_offset` = address bits [7:0], `ch_we` = `req_we` and `ch_wdata` = `req_wdata[7:0]`.
- R4: A read routed to a channel returns that channel's 8-bit `ch_rdata` byte in bits [7:0] of `rsp_rdata`, with bits [31:8] zero.
- R5: A request whose local offset inside a channel window is 0x100 to 0x1FF (address bit 8 set) raises no select, and a read of it returns zero.
- R6: A channel-window request below local offset 0x100 with any size code other than 0 raises no select, and a read of it returns zero.
- R7: A request whose channel index is NUM_CH or more raises no select, and a read of it returns zero.
- R8: At most one of `glb_sel` and `ch_sel` bits is high in any cycle, and none is high unless a request is accepted (`req_valid` and `req_ready`).
- R9: `rsp_valid` is high for exactly the one cycle after each accepted read and never after an accepted write. `rsp_rdata` is valid in that cycle.
- R10: While reset is asserted and in the first cycle after release, `req_ready` is low. During reset `rsp_valid` and all selects are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Decoder can take a request |
| req_addr | input | 14 | Byte offset in the register space |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width: 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 32 | Read response data |
| glb_sel | output | 1 | Shared bank select |
| glb_we | output | 1 | Shared bank write enable |
| glb_offset | output | 12 | Offset inside the shared bank |
| glb_wdata | output | 32 | Shared bank write data |
| glb_rdata | input | 32 | Shared bank read data for the current offset |
| ch_sel | output | NUM_CH | One select per channel |
| ch_we | output | 1 | Channel write enable |
| ch_offset | output | 8 | Register offset inside the channel |
| ch_wdata | output | 8 | Channel write byte |
| ch_rdata | input | NUM_CH*8 | Read byte of each channel, channel n in bits [8n+7:8n] |

## Verification
The assertions assume that the shared bank and channel read data are valid in the same cycle as the select, combinationally from the offset. They also assume that `req_valid` is held low during reset. The bench ties the read-data inputs to fixed functions of the offset and channel number, and it raises `req_valid` only after `req_ready` is seen. The stimulus stays inside the 14-bit space. It is built with fewer channels than windows, so that windows past the built count can be reached.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

  // Access width code carried on req_size
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  // Where a request lands after decode
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_GLB  = 2'd1,
    TGT_CH   = 2'd2
  } tgt_e;

endpackage

// File: rtl/mwd_classify.sv
module mwd_classify
  import mwd_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int GLB_OFF_W = 12,
  parameter int WIN_SHIFT = 9,
  parameter int REG_OFF_W = 8,
  parameter int IDX_W     = 5,
  parameter int NUM_CH    = 16,
  localparam int HI_W     = ADDR_W - REG_OFF_W
) (
  input  logic [HI_W-1:0]  hi_addr,
  input  logic [1:0]       size,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] idx
);

  localparam int GLB_HI_LSB = GLB_OFF_W - REG_OFF_W;
  localparam int WIN_HI_LSB = WIN_SHIFT - REG_OFF_W;
  localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'((1 << GLB_OFF_W) >> WIN_SHIFT);
  localparam logic [IDX_W:0]   NCH_CMP  = (IDX_W+1)'(NUM_CH);

  logic             is_glb;
  logic             in_dma;
  logic             in_range;
  logic [IDX_W-1:0] win_num;

  always_comb begin
    is_glb   = (hi_addr[HI_W-1:GLB_HI_LSB] == '0);
    win_num  = hi_addr[HI_W-1:WIN_HI_LSB];
    idx      = win_num - BASE_IDX;
    in_dma   = |hi_addr[WIN_HI_LSB-1:0];
    in_range = ({1'b0, idx} < NCH_CMP);
    tgt      = TGT_NONE;
    if (is_glb) begin
      if (size == SZ_WORD) tgt = TGT_GLB;
    end else if (!in_dma && in_range && size == SZ_BYTE) begin
      tgt = TGT_CH;
    end
  end

endmodule

// File: rtl/mwd_strobe.sv
module mwd_strobe
  import mwd_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = 5
) (
  input  logic              acc,
  input  tgt_e              tgt,
  input  logic [IDX_W-1:0]  idx,
  output logic              glb_sel,
  output logic [NUM_CH-1:0] ch_sel
);

  assign glb_sel = acc && (tgt == TGT_GLB);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign ch_sel[g] = acc && (tgt == TGT_CH) && (idx == IDX_W'(g));
  end

endmodule

// File: rtl/mwd_rsp.sv
module mwd_rsp
  import mwd_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32,
  parameter int CH_DW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_acc,
  input  tgt_e                    tgt,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DATA_W-1:0]       glb_rdata,
  input  logic [NUM_CH*CH_DW-1:0] ch_rdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata
);

  logic [CH_DW-1:0]  ch_byte;
  logic              vld_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    ch_byte = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (idx == IDX_W'(i)) ch_byte = ch_rdata[i*CH_DW +: CH_DW];
    end
  end

  always_comb begin
    vld_d  = rd_acc;
    data_d = '0;
    case (tgt)
      TGT_GLB: data_d = glb_rdata;
      TGT_CH:  data_d = DATA_W'(ch_byte);
      default: data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= vld_d;
      if (rd_acc) rsp_rdata <= data_d;
    end
  end

endmodule

// File: rtl/mmio_win_decoder.sv
module mmio_win_decoder
  import mwd_pkg::*;
#(
  parameter int SPACE_BYTES = 16384,
  parameter int GLB_BYTES   = 4096,
  parameter int WIN_BYTES   = 512,
  parameter int REG_BYTES   = 256,
  parameter int NUM_CH      = 16,
  parameter int DATA_W      = 32,
  parameter int CH_DW       = 8,
  localparam int ADDR_W     = $clog2(SPACE_BYTES),
  localparam int GLB_OFF_W  = $clog2(GLB_BYTES),
  localparam int REG_OFF_W  = $clog2(REG_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_we,
  input  logic [1:0]              req_size,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    glb_sel,
  output logic                    glb_we,
  output logic [GLB_OFF_W-1:0]    glb_offset,
  output logic [DATA_W-1:0]       glb_wdata,
  input  logic [DATA_W-1:0]       glb_rdata,
  output logic [NUM_CH-1:0]       ch_sel,
  output logic                    ch_we,
  output logic [REG_OFF_W-1:0]    ch_offset,
  output logic [CH_DW-1:0]        ch_wdata,
  input  logic [NUM_CH*CH_DW-1:0] ch_rdata
);

  localparam int WIN_SHIFT = $clog2(WIN_BYTES);
  localparam int IDX_W     = ADDR_W - WIN_SHIFT;

  logic             ready_q;
  logic             ready_d;
  logic             acc;
  logic             rd_acc;
  tgt_e             tgt;
  logic [IDX_W-1:0] idx;

  // Ready rises one cycle after reset release
  always_comb ready_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  assign req_ready = ready_q;
  assign acc       = req_valid && ready_q;
  assign rd_acc    = acc && !req_we;

  mwd_classify #(
    .ADDR_W(ADDR_W), .GLB_OFF_W(GLB_OFF_W), .WIN_SHIFT(WIN_SHIFT),
    .REG_OFF_W(REG_OFF_W), .IDX_W(IDX_W), .NUM_CH(NUM_CH)
  ) u_classify (
    .hi_addr (req_addr[ADDR_W-1:REG_OFF_W]),
    .size    (req_size),
    .tgt     (tgt),
    .idx     (idx)
  );

  mwd_strobe #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_strobe (
    .acc     (acc),
    .tgt     (tgt),
    .idx     (idx),
    .glb_sel (glb_sel),
    .ch_sel  (ch_sel)
  );

  mwd_rsp #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .DATA_W(DATA_W), .CH_DW(CH_DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_acc    (rd_acc),
    .tgt       (tgt),
    .idx       (idx),
    .glb_rdata (glb_rdata),
    .ch_rdata  (ch_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign glb_we     = req_we;
  assign glb_offset = req_addr[GLB_OFF_W-1:0];
  assign glb_wdata  = req_wdata;
  assign ch_we      = req_we;
  assign ch_offset  = req_addr[REG_OFF_W-1:0];
  assign ch_wdata   = req_wdata[CH_DW-1:0];

endmodule

// File: rtl/mmio_win_decoder_chk.sv
module mmio_win_decoder_chk #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [13:0]       req_addr,
  input logic              req_we,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              glb_sel,
  input logic [NUM_CH-1:0] ch_sel
);

  logic acc_c;
  logic in_win_c;
  logic past_end_c;
  assign acc_c      = req_valid && req_ready;
  assign in_win_c   = (req_addr[13:12] != 2'b00);
  assign past_end_c = in_win_c && ({1'b0, req_addr[13:9]} >= 6'(8 + NUM_CH));

  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({glb_sel, ch_sel}));

  // R8
  sel_needs_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_sel || (|ch_sel)) |-> acc_c);

  // R1
  glb_word_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glb_sel |-> (req_size == 2'd2 && !in_win_c));

  // R6
  ch_byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_sel) |-> (req_size == 2'd0 && !req_addr[8]));

  // R7
  past_end_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_end_c |-> (ch_sel == '0));

  // R9
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && !req_we) |=> rsp_valid);

  // R9
  no_rsp_otherwise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_c && !req_we) |=> !rsp_valid);

  // R5
  dma_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && !req_we && in_win_c && req_addr[8]) |=> (rsp_rdata == 32'd0));

endmodule

bind mmio_win_decoder mmio_win_decoder_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_we    (req_we),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .glb_sel   (glb_sel),
  .ch_sel    (ch_sel)
);

// File: tb/test_mmio_win_decoder.sv
`timescale 1ns/1ps
module test_mmio_win_decoder;

  localparam int NCH = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [13:0]       req_addr;
  logic              req_we;
  logic [1:0]        req_size;
  logic [31:0]       req_wdata;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              glb_sel;
  logic              glb_we;
  logic [11:0]       glb_offset;
  logic [31:0]       glb_wdata;
  logic [31:0]       glb_rdata;
  logic [NCH-1:0]    ch_sel;
  logic              ch_we;
  logic [7:0]        ch_offset;
  logic [7:0]        ch_wdata;
  logic [NCH*8-1:0]  ch_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { bit is_rd; logic [31:0] data; string tag; } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  assign glb_rdata = 32'hC0DE_0000 | {20'd0, glb_offset};
  for (genvar g = 0; g < NCH; g++) begin : g_chd
    assign ch_rdata[g*8 +: 8] = 8'(8'h40 + g*3);
  end

  mmio_win_decoder #(.NUM_CH(NCH)) i_mmio_win_decoder (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model: -1 none, -2 shared bank, else channel index
  function automatic int model_tgt(input int addr, input int size);
    int idx, loc;
    if (addr < 'h1000) return (size == 2) ? -2 : -1;
    idx = (addr - 'h1000) / 'h200;
    loc = (addr - 'h1000) % 'h200;
    if (loc >= 'h100 || idx >= NCH || size != 0) return -1;
    return idx;
  endfunction

  function automatic logic [31:0] model_rd(input int addr, input int size);
    int t;
    t = model_tgt(addr, size);
    if (t == -2) return 32'hC0DE_0000 | (addr & 'hFFF);
    if (t >= 0)  return 32'(8'(8'h40 + t*3));
    return 32'd0;
  endfunction

  task automatic access(input int addr, input bit we, input int size,
                        input logic [31:0] wd, input string tag);
    int t;
    logic [NCH-1:0] exp_sel;
    item_t it;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 14'(addr);
    req_we    = we;
    req_size  = 2'(size);
    req_wdata = wd;
    #1;
    t = model_tgt(addr, size);
    exp_sel = '0;
    if (t >= 0) exp_sel[t] = 1'b1;
    chk(glb_sel == (t == -2), {tag, " glb_sel"}, 32'(glb_sel), 32'(t == -2));
    chk(ch_sel == exp_sel, {tag, " ch_sel"}, 32'(ch_sel), 32'(exp_sel));
    if (t == -2) begin
      chk(glb_offset == 12'(addr) && glb_we == we && glb_wdata == wd,
          {tag, " glb fields"}, {glb_offset, 19'd0, glb_we}, {12'(addr), 19'd0, we});
    end
    if (t >= 0) begin
      chk(ch_offset == 8'(addr) && ch_we == we && ch_wdata == wd[7:0],
          {tag, " ch fields"}, {15'd0, ch_we, ch_offset, ch_wdata}, {15'd0, we, 8'(addr), wd[7:0]});
    end
    it.is_rd = !we;
    it.data  = we ? 32'd0 : model_rd(addr, size);
    it.tag   = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compare the response one cycle after each accepted request
  bit acc_seen = 1'b0;
  always @(posedge clk) acc_seen <= req_valid && req_ready;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (acc_seen) begin
        item_t it;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R9 scoreboard empty", 32'd0, 32'd1);
        end else begin
          it = sb_q.pop_front();
          chk(rsp_valid == it.is_rd, {it.tag, " R9 rsp_valid"}, 32'(rsp_valid), 32'(it.is_rd));
          if (it.is_rd)
            chk(rsp_rdata == it.data, {it.tag, " rsp_rdata"}, rsp_rdata, it.data);
        end
      end else if (rsp_valid) begin
        chk(1'b0, "R9 unexpected rsp_valid", 32'd1, 32'd0);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_we = 1'b0;
    req_size = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !req_ready && !glb_sel && ch_sel == '0, "R10 reset state",
        {30'd0, rsp_valid, req_ready}, 32'd0);
    rst_n = 1'b1;
    #1;
    chk(!req_ready, "R10 ready low after release", 32'(req_ready), 32'd0);
    while (!req_ready) @(negedge clk);

    // R1 shared bank word accesses
    access('h008, 1'b0, 2, 32'h0, "R1 glb read");
    access('h00C, 1'b1, 2, 32'hDEAD_BEEF, "R1 glb write");
    access('hFFC, 1'b0, 2, 32'h0, "R1 glb read top");
    // R2 shared bank wrong width
    access('h004, 1'b0, 0, 32'h0, "R2 glb byte read");
    access('h010, 1'b0, 1, 32'h0, "R2 glb half read");
    access('h014, 1'b1, 3, 32'h1234_5678, "R2 glb rsvd write");
    // R3 / R4 channel byte accesses
    access('h1003, 1'b1, 0, 32'hFFFF_FF5A, "R3 ch0 write");
    access('h1A42, 1'b0, 0, 32'h0, "R4 ch5 read");
    access('h1000 + 11*'h200 + 'hFF, 1'b0, 0, 32'h0, "R4 ch11 read last");
    access('h1000 + 7*'h200, 1'b1, 0, 32'h0000_00A7, "R3 ch7 write");
    idle();
    // R5 reserved transfer-engine area
    access('h1100, 1'b0, 0, 32'h0, "R5 dma read");
    access('h1000 + 3*'h200 + 'h1FF, 1'b1, 0, 32'h0000_0011, "R5 dma write");
    access('h1000 + 2*'h200 + 'h180, 1'b0, 2, 32'h0, "R5 dma word read");
    // R6 channel wrong width
    access('h1204, 1'b0, 2, 32'h0, "R6 ch word read");
    access('h1406, 1'b1, 1, 32'h0000_BEEF, "R6 ch half write");
    // R7 beyond built channel count
    access('h1000 + 12*'h200, 1'b0, 0, 32'h0, "R7 ch12 read");
    access('h3E00, 1'b1, 0, 32'h0000_0077, "R7 ch23 write");
    access('h3FFF, 1'b0, 0, 32'h0, "R7 last byte read");
    idle();
    // R8 / R9 back-to-back mix
    for (int i = 0; i < NCH; i++) begin
      access('h1000 + i*'h200 + i, (i % 2) == 1, 0, 32'(i), "R8 sweep");
    end
    idle();
    idle();
    chk(sb_q.size() == 0, "R9 all responses seen", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule